// File: doc/BRIEF.md
# Row Retirement Column Sweeper

This block runs the page-retirement walk that follows an uncorrectable DRAM error. It takes the 28-bit DRAM address of the failing access and works through every column of the failing row and bank. For each of the 32 column values it writes that value into the address and asks an external translator for the system physical address. When the translation succeeds, it asks a page-status store whether the matching 4 KiB frame is online and whether it is already poisoned. It sends a retire command only for frames that are online and not yet poisoned.

The translator and the page-status store sit outside the block. The translator request is a one-cycle pulse, and its answer is a one-cycle pulse that may come any number of cycles later. The page query is a level request that stays up until its one-cycle answer arrives. The block also keeps two counts: frames retired and columns skipped. Both counts can be read when the done pulse fires.

Top module: `row_retire_sweeper`

## Requirements
- R1: An error record is taken only when the block is idle. A `rec_valid` pulse that arrives while `busy` is high is ignored: the sweep in progress keeps its own address, and no second sweep follows.
- R2: For a record address A, column values 0 to 31 are issued in ascending order, one per `xl_req_valid` pulse. Each pulse carries A with bits 5:1 replaced by the current column value and every other bit of A unchanged. Each pulse lasts exactly one cycle.
- R3: When the translator answers with `xl_rsp_err` high, that column is counted as skipped, no page query is raised for it, and the sweep moves on to the next column.
- R4: The frame number is the translated address shifted right by 12. It is presented on `pg_req_pfn` during the page query and on `ret_pfn` during the retire pulse.
- R5: A column whose frame is reported as not online (`pg_rsp_online` low) is skipped without a retire command.
- R6: A column whose frame is online but already poisoned (`pg_rsp_poison` high) is skipped without a retire command.
- R7: A frame reported as online and not poisoned produces exactly one `ret_valid` pulse, one cycle long. Retire pulses come in ascending column order.
- R8: After column 31 is finished, `done` is high for exactly one cycle. In the cycle after that, the block is idle again.
- R9: `busy` goes high in the cycle after a record is accepted and stays high up to and including the `done` cycle. While the block is idle, no request or retire output is active.
- R10: At `done`, `retired_cnt` equals the number of retire pulses in the sweep, and `retired_cnt + skipped_cnt` equals 32. Both counts are cleared when a new record is accepted.
- R11: After reset, `busy`, `done`, `xl_req_valid`, `pg_req_valid` and `ret_valid` are low, and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_valid | input | 1 | Error record present; taken only when idle |
| rec_addr | input | 28 (ADDR_W) | DRAM address from the error record |
| busy | output | 1 | Sweep in progress |
| xl_req_valid | output | 1 | One-cycle translation request |
| xl_req_addr | output | 28 (ADDR_W) | Record address with the current column substituted |
| xl_rsp_valid | input | 1 | One-cycle translation answer |
| xl_rsp_err | input | 1 | Translation failed |
| xl_rsp_addr | input | 48 (SPA_W) | Translated system physical address |
| pg_req_valid | output | 1 | Page status query, held until answered |
| pg_req_pfn | output | 36 (SPA_W-PG_SHIFT) | Frame number being queried |
| pg_rsp_valid | input | 1 | One-cycle page status answer |
| pg_rsp_online | input | 1 | Frame is valid and online |
| pg_rsp_poison | input | 1 | Frame is already poisoned |
| ret_valid | output | 1 | One-cycle retire command |
| ret_pfn | output | 36 (SPA_W-PG_SHIFT) | Frame number to retire |
| done | output | 1 | One-cycle end-of-sweep pulse |
| retired_cnt | output | 6 | Frames retired in the current or last sweep |
| skipped_cnt | output | 6 | Columns skipped in the current or last sweep |

## Verification
A record sampled at a clock edge raises `busy` and the first `xl_req_valid` one cycle later. A translator answer sampled in the wait state puts up the page query one cycle later, or moves straight to the next column on an error. A clean page answer raises `ret_valid` one cycle after it is sampled. Each column then spends one extra cycle in the advance step, and `done` follows the last column's advance by one cycle. The bench stubs drive their answers on falling edges after a set latency, so every answer is stable across the rising edge that samples it. The bench logs requests, queries and retire pulses on falling edges, and it reads the counts in the falling-edge window where `done` is high.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    parameter int RRS_ADDR_W   = 28;
    parameter int RRS_COL_LSB  = 1;
    parameter int RRS_COL_W    = 5;
    parameter int RRS_SPA_W    = 48;
    parameter int RRS_PG_SHIFT = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT_XL,
        ST_CHECK,
        ST_RETIRE,
        ST_NEXT,
        ST_DONE
    } sweep_st_e;

    typedef enum logic [1:0] {
        PG_RETIRE,
        PG_SKIP_OFFLINE,
        PG_SKIP_POISON
    } page_act_e;

endpackage

// File: rtl/rrs_col_subst.sv
module rrs_col_subst #(
    parameter int ADDR_W  = 28,
    parameter int COL_LSB = 1,
    parameter int COL_W   = 5
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [COL_W-1:0]  col_i,
    output logic [ADDR_W-1:0] addr_o
);

    // Bits inside the column field come from the sweep counter.
    // All other bits pass through from the record.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b >= COL_LSB && b < COL_LSB + COL_W) begin : g_col
            assign addr_o[b] = col_i[b-COL_LSB];
        end else begin : g_keep
            assign addr_o[b] = base_i[b];
        end
    end

    logic unused_old_col;
    assign unused_old_col = ^base_i[COL_LSB +: COL_W];

endmodule

// File: rtl/rrs_page_judge.sv
module rrs_page_judge
    import rrs_pkg::*;
(
    input  logic      online_i,
    input  logic      poison_i,
    output page_act_e act_o
);

    // An offline frame is never inspected for poison.
    always_comb begin
        if (!online_i)     act_o = PG_SKIP_OFFLINE;
        else if (poison_i) act_o = PG_SKIP_POISON;
        else               act_o = PG_RETIRE;
    end

endmodule

// File: rtl/rrs_tally.sv
module rrs_tally #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             ret_i,
    input  logic             skip_i,
    output logic [CNT_W-1:0] ret_cnt_o,
    output logic [CNT_W-1:0] skip_cnt_o
);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            ret_cnt_o  <= '0;
            skip_cnt_o <= '0;
        end else begin
            if (ret_i)  ret_cnt_o  <= ret_cnt_o + 1'b1;
            if (skip_i) skip_cnt_o <= skip_cnt_o + 1'b1;
        end
    end

    // A column finishes either as a retire or as a skip, never as both.
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
        !(ret_i && skip_i));

endmodule

// File: rtl/row_retire_sweeper.sv
module row_retire_sweeper
    import rrs_pkg::*;
#(
    parameter int ADDR_W   = RRS_ADDR_W,
    parameter int COL_LSB  = RRS_COL_LSB,
    parameter int COL_W    = RRS_COL_W,
    parameter int SPA_W    = RRS_SPA_W,
    parameter int PG_SHIFT = RRS_PG_SHIFT,
    localparam int NCOL    = 1 << COL_W,
    localparam int PFN_W   = SPA_W - PG_SHIFT,
    localparam int CNT_W   = $clog2(NCOL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_valid,
    input  logic [ADDR_W-1:0] rec_addr,
    output logic              busy,
    output logic              xl_req_valid,
    output logic [ADDR_W-1:0] xl_req_addr,
    input  logic              xl_rsp_valid,
    input  logic              xl_rsp_err,
    input  logic [SPA_W-1:0]  xl_rsp_addr,
    output logic              pg_req_valid,
    output logic [PFN_W-1:0]  pg_req_pfn,
    input  logic              pg_rsp_valid,
    input  logic              pg_rsp_online,
    input  logic              pg_rsp_poison,
    output logic              ret_valid,
    output logic [PFN_W-1:0]  ret_pfn,
    output logic              done,
    output logic [CNT_W-1:0]  retired_cnt,
    output logic [CNT_W-1:0]  skipped_cnt
);

    sweep_st_e         st_q, st_d;
    logic [ADDR_W-1:0] rec_q;
    logic [COL_W-1:0]  col_q;
    logic [PFN_W-1:0]  pfn_q;
    page_act_e         page_act;
    logic              accept, last_col, xl_ok, xl_bad, pg_skip;

    assign accept   = (st_q == ST_IDLE) && rec_valid;
    assign last_col = &col_q;
    assign xl_ok    = (st_q == ST_WAIT_XL) && xl_rsp_valid && !xl_rsp_err;
    assign xl_bad   = (st_q == ST_WAIT_XL) && xl_rsp_valid && xl_rsp_err;
    assign pg_skip  = (st_q == ST_CHECK) && pg_rsp_valid && (page_act != PG_RETIRE);

    rrs_col_subst #(
        .ADDR_W (ADDR_W),
        .COL_LSB(COL_LSB),
        .COL_W  (COL_W)
    ) u_subst (
        .base_i(rec_q),
        .col_i (col_q),
        .addr_o(xl_req_addr)
    );

    rrs_page_judge u_judge (
        .online_i(pg_rsp_online),
        .poison_i(pg_rsp_poison),
        .act_o   (page_act)
    );

    rrs_tally #(.CNT_W(CNT_W)) u_tally (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (accept),
        .ret_i     (st_q == ST_RETIRE),
        .skip_i    (xl_bad || pg_skip),
        .ret_cnt_o (retired_cnt),
        .skip_cnt_o(skipped_cnt)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (rec_valid) st_d = ST_REQ;
            ST_REQ:     st_d = ST_WAIT_XL;
            ST_WAIT_XL: if (xl_rsp_valid) st_d = xl_rsp_err ? ST_NEXT : ST_CHECK;
            ST_CHECK:   if (pg_rsp_valid)
                            st_d = (page_act == PG_RETIRE) ? ST_RETIRE : ST_NEXT;
            ST_RETIRE:  st_d = ST_NEXT;
            ST_NEXT:    st_d = last_col ? ST_DONE : ST_REQ;
            ST_DONE:    st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            rec_q <= '0;
            col_q <= '0;
            pfn_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                rec_q <= rec_addr;
                col_q <= '0;
            end
            if (st_q == ST_NEXT && !last_col) col_q <= col_q + 1'b1;
            if (xl_ok) pfn_q <= xl_rsp_addr[SPA_W-1:PG_SHIFT];
        end
    end

    logic unused_page_offset;
    assign unused_page_offset = ^xl_rsp_addr[PG_SHIFT-1:0];

    assign busy         = (st_q != ST_IDLE);
    assign done         = (st_q == ST_DONE);
    assign xl_req_valid = (st_q == ST_REQ);
    assign pg_req_valid = (st_q == ST_CHECK);
    assign ret_valid    = (st_q == ST_RETIRE);
    assign pg_req_pfn   = pfn_q;
    assign ret_pfn      = pfn_q;

    p_ignore_busy_rec_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && rec_valid) |=> $stable(rec_q));

    p_req_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        xl_req_valid |=> !xl_req_valid);

    p_err_no_query_r3: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_WAIT_XL) && xl_rsp_valid && xl_rsp_err) |=> !pg_req_valid);

    p_retire_clean_r7: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> $past(pg_rsp_valid && pg_rsp_online && !pg_rsp_poison));

    p_done_then_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(xl_req_valid || pg_req_valid || ret_valid));

    p_total_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(retired_cnt) + int'(skipped_cnt) == NCOL));

endmodule

// File: tb/row_retire_sweeper_tb.sv
module row_retire_sweeper_tb;

    localparam int AW = 28;
    localparam int SW = 48;
    localparam int PS = 12;
    localparam int PW = SW - PS;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rec_valid = 1'b0;
    logic [AW-1:0] rec_addr = '0;
    logic          busy, xl_req_valid, pg_req_valid, ret_valid, done;
    logic [AW-1:0] xl_req_addr;
    logic          xl_rsp_valid = 1'b0;
    logic          xl_rsp_err = 1'b0;
    logic [SW-1:0] xl_rsp_addr = '0;
    logic [PW-1:0] pg_req_pfn, ret_pfn;
    logic          pg_rsp_valid = 1'b0;
    logic          pg_rsp_online = 1'b0;
    logic          pg_rsp_poison = 1'b0;
    logic [CW-1:0] retired_cnt, skipped_cnt;

    row_retire_sweeper u_dut (
        .clk(clk), .rst(rst),
        .rec_valid(rec_valid), .rec_addr(rec_addr), .busy(busy),
        .xl_req_valid(xl_req_valid), .xl_req_addr(xl_req_addr),
        .xl_rsp_valid(xl_rsp_valid), .xl_rsp_err(xl_rsp_err), .xl_rsp_addr(xl_rsp_addr),
        .pg_req_valid(pg_req_valid), .pg_req_pfn(pg_req_pfn),
        .pg_rsp_valid(pg_rsp_valid), .pg_rsp_online(pg_rsp_online), .pg_rsp_poison(pg_rsp_poison),
        .ret_valid(ret_valid), .ret_pfn(ret_pfn), .done(done),
        .retired_cnt(retired_cnt), .skipped_cnt(skipped_cnt)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    int wd = 0;

    // Stub configuration
    int            xl_lat = 1;
    int            pg_lat = 1;
    logic [31:0]   err_mask = '0;
    logic [31:0]   off_mask = '0;
    logic [31:0]   poi_mask = '0;
    logic [SW-1:0] spa_base = 48'h0012_3450_0000;
    logic [PW-1:0] base_pfn;
    assign base_pfn = spa_base[SW-1:PS];

    // Logs
    logic [AW-1:0] req_log [0:63];
    logic [PW-1:0] ret_log [0:63];
    int req_n = 0;
    int ret_n = 0;
    int pg_n = 0;

    // Translator stub: frame for column c is base + c, with a nonzero offset.
    int       xw = 0;
    logic [4:0] xcol = '0;
    always @(negedge clk) begin
        xl_rsp_valid = 1'b0;
        if (xw > 0) begin
            xw--;
            if (xw == 0) begin
                xl_rsp_valid = 1'b1;
                xl_rsp_err   = err_mask[xcol];
                xl_rsp_addr  = spa_base + (SW'(xcol) << PS) + SW'(12'h5A8);
            end
        end
        if (xl_req_valid) begin
            xw   = xl_lat;
            xcol = xl_req_addr[5:1];
            if (req_n < 64) req_log[req_n] = xl_req_addr;
            req_n++;
        end
    end

    // Page status stub, keyed by frame number.
    logic pg_prev = 1'b0;
    int   pw = 0;
    int   pidx = 0;
    always @(negedge clk) begin
        pg_rsp_valid = 1'b0;
        if (pw > 0) begin
            pw--;
            if (pw == 0) begin
                pg_rsp_valid  = 1'b1;
                pg_rsp_online = !off_mask[pidx];
                pg_rsp_poison = poi_mask[pidx];
            end
        end
        if (pg_req_valid && !pg_prev) begin
            pw   = pg_lat;
            pidx = int'(pg_req_pfn - base_pfn) & 31;
            pg_n++;
        end
        pg_prev = pg_req_valid;
        if (ret_valid) begin
            if (ret_n < 64) ret_log[ret_n] = ret_pfn;
            ret_n++;
        end
    end

    task automatic chk(input string req, input string ctx, input bit ok,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, ctx, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", wd, 150000);
            finish_run();
        end
    end

    // Run one sweep; optionally pulse a second record at cycle intrude_at.
    task automatic run_sweep(input string ctx, input logic [AW-1:0] addr,
                             input int intrude_at, input logic [AW-1:0] addr2);
        int  cyc;
        int  busy_bad;
        bit  got_done;
        logic [CW-1:0] rc, sc;
        int  exp_ret, exp_pg, first_bad, rk;
        logic [AW-1:0] exp_a;
        logic [AW-1:0] bad_a;
        logic [PW-1:0] bad_p;

        @(posedge clk);
        req_n = 0; ret_n = 0; pg_n = 0;
        @(negedge clk);
        rec_valid = 1'b1;
        rec_addr  = addr;
        @(negedge clk);
        rec_valid = 1'b0;
        cyc = 0; busy_bad = 0; got_done = 1'b0; rc = '0; sc = '0;
        while (!got_done && cyc < 5000) begin
            if (!busy) busy_bad++;
            if (done) begin
                got_done = 1'b1;
                rc = retired_cnt;
                sc = skipped_cnt;
            end
            if (cyc == intrude_at) begin
                rec_valid = 1'b1;
                rec_addr  = addr2;
            end else begin
                rec_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        rec_valid = 1'b0;

        chk("R8", {ctx, " done seen"}, got_done, 64'(got_done), 64'd1);
        chk("R8", {ctx, " idle after done"}, !busy && !done, {62'd0, busy, done}, 64'd0);
        chk("R9", {ctx, " busy gaps"}, busy_bad == 0, 64'(busy_bad), 64'd0);

        // R2: ascending columns with other bits preserved
        chk("R2", {ctx, " request count"}, req_n == 32, 64'(req_n), 64'd32);
        first_bad = -1; bad_a = '0; exp_a = '0;
        for (int c = 0; c < 32 && c < req_n; c++) begin
            logic [AW-1:0] e;
            e = (addr & ~(AW'(5'h1F) << 1)) | (AW'(c) << 1);
            if (first_bad < 0 && req_log[c] != e) begin
                first_bad = c; bad_a = req_log[c]; exp_a = e;
            end
        end
        chk("R2", {ctx, " request address"}, first_bad < 0, 64'(bad_a), 64'(exp_a));

        exp_ret = 0; exp_pg = 0;
        for (int c = 0; c < 32; c++) begin
            if (!err_mask[c]) exp_pg++;
            if (!err_mask[c] && !off_mask[c] && !poi_mask[c]) exp_ret++;
        end
        chk("R3", {ctx, " page queries"}, pg_n == exp_pg, 64'(pg_n), 64'(exp_pg));
        chk("R7", {ctx, " retire pulses"}, ret_n == exp_ret, 64'(ret_n), 64'(exp_ret));

        // R4: retired frames in column order, frame = address >> 12
        rk = 0; first_bad = -1; bad_p = '0;
        for (int c = 0; c < 32; c++) begin
            if (!err_mask[c] && !off_mask[c] && !poi_mask[c]) begin
                if (rk < ret_n && rk < 64 && first_bad < 0 &&
                    ret_log[rk] != base_pfn + PW'(c)) begin
                    first_bad = c; bad_p = ret_log[rk];
                end
                rk++;
            end
        end
        chk("R4", {ctx, " retire frame"}, first_bad < 0, 64'(bad_p),
            64'(base_pfn + PW'(first_bad < 0 ? 0 : first_bad)));

        chk("R10", {ctx, " retired count"}, int'(rc) == exp_ret, 64'(rc), 64'(exp_ret));
        chk("R10", {ctx, " skipped count"}, int'(sc) == 32 - exp_ret, 64'(sc), 64'(32 - exp_ret));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "reset outputs", !busy && !done && !xl_req_valid && !pg_req_valid && !ret_valid,
            {59'd0, busy, done, xl_req_valid, pg_req_valid, ret_valid}, 64'd0);
        chk("R11", "reset counts", retired_cnt == 0 && skipped_cnt == 0,
            {52'd0, retired_cnt, skipped_cnt}, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_all_clean();
        xl_lat = 1; pg_lat = 1;
        err_mask = '0; off_mask = '0; poi_mask = '0;
        run_sweep("clean", 28'h0A5_5A40, -1, '0);
    endtask

    task automatic t_offline();   // R5
        xl_lat = 2; pg_lat = 1;
        err_mask = '0; off_mask = 32'h8000_F00F; poi_mask = '0;
        run_sweep("R5 offline", 28'hFFF_FFFF, -1, '0);
    endtask

    task automatic t_poison();    // R6
        xl_lat = 1; pg_lat = 3;
        err_mask = '0; off_mask = '0; poi_mask = 32'h0F0F_0001;
        run_sweep("R6 poisoned", 28'h123_4566, -1, '0);
    endtask

    task automatic t_mixed();
        xl_lat = 3; pg_lat = 2;
        err_mask = 32'h1111_0004; off_mask = 32'h2200_0480; poi_mask = 32'h4403_0800;
        run_sweep("mixed", 28'h800_003E, -1, '0);
    endtask

    task automatic t_all_err();   // R3
        xl_lat = 1; pg_lat = 1;
        err_mask = 32'hFFFF_FFFF; off_mask = '0; poi_mask = '0;
        run_sweep("R3 all errors", 28'h5F0_0000, -1, '0);
    endtask

    task automatic t_intrude();   // R1
        int extra;
        xl_lat = 1; pg_lat = 1;
        err_mask = 32'h0000_0100; off_mask = '0; poi_mask = 32'h0000_0002;
        run_sweep("R1 busy record", 28'h0C3_0C00, 7, 28'hF3C_F3FE);
        extra = req_n;
        repeat (6) @(negedge clk);
        chk("R1", "no second sweep", req_n == extra && !busy, 64'(req_n), 64'(extra));
    endtask

    initial begin
        t_reset();
        t_all_clean();
        t_offline();
        t_poison();
        t_mixed();
        t_all_err();
        t_intrude();
        finish_run();
    end

endmodule